// File: doc/BRIEF.md
# EX-Stage Operand Bypass Selector

This block decides, for each of the two source operands of the instruction in the execute stage of a five-stage 32-bit integer pipeline, where that operand's value should come from. The three possible sources are the register-file read, the result held in the memory-access stage, or the result held in the write-back stage. It compares the two source register indices against the destination index and write-enable of the two older instructions. It then produces a 2-bit select code for each operand and uses that code to pick the operand data.

Each operand has its own copy of the match logic and the multiplexer, and the two copies run independently. The select codes and the chosen operand data leave the block through a register stage with synchronous active-high reset. They are valid one clock after the indices and data are presented. Register x0 never takes part in bypassing. When both older instructions write the same register, the value from the memory-access stage is chosen, because it is the newer one. Load-use stall detection and the register file itself sit outside this block.

Top module: `ex_bypass_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs become zero at that edge.
- R2: Each output reflects the inputs sampled at the previous rising edge, so the latency is exactly one cycle.
- R3: If `mem_wen` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals an operand's source index, that operand's select is 1 and its data is `mem_result`.
- R4: If the memory-stage condition of R3 does not hold for an operand, but `wb_wen` is 1, `wb_dst_idx` is nonzero and `wb_dst_idx` equals that operand's source index, the select is 2 and the data is `wb_result`.
- R5: If both the memory-stage and the write-back-stage conditions hold for an operand, the select is 1 and the data is `mem_result`.
- R6: An operand whose source index is 0 always gets select 0 and its register-file data, even when a producer writes index 0 with its write-enable high.
- R7: A producer whose write-enable is 0 is never bypassed. With no match, the select is 0 and the data is the operand's register-file input.
- R8: Operand 1 depends only on `ex_src1_idx`/`rf_src1_data`, and operand 2 depends only on `ex_src2_idx`/`rf_src2_data`. The two operands may use different sources in the same cycle.
- R9: Select code 3 never appears on `sel1_q` or `sel2_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_src1_idx | input | 5 | First source register index of the EX instruction |
| ex_src2_idx | input | 5 | Second source register index of the EX instruction |
| rf_src1_data | input | 32 | Register-file value for the first source |
| rf_src2_data | input | 32 | Register-file value for the second source |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst_idx | input | 5 | Memory-stage destination index |
| mem_result | input | 32 | Memory-stage result value |
| wb_wen | input | 1 | Write-back-stage instruction writes a register |
| wb_dst_idx | input | 5 | Write-back-stage destination index |
| wb_result | input | 32 | Write-back-stage result value |
| sel1_q | output | 2 | Registered select for operand 1 (0 file, 1 memory stage, 2 write-back) |
| sel2_q | output | 2 | Registered select for operand 2 |
| opnd1_q | output | 32 | Registered operand 1 data |
| opnd2_q | output | 32 | Registered operand 2 data |

## Verification
The hardest case to reach is the one where both older instructions write the same register that the current instruction reads, with different values. A wrong priority shows up only in that case. The stimulus models a running pipeline: every step, a new producer enters the memory stage, the previous one moves to write-back, and the oldest commits to a bench register-file model. Indices are drawn from a small range (x0 to x3), so back-to-back writes to the same register and reads of x0 occur often. The expected operand is the architecturally newest value of each register, and this value is kept in a separate model.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_MEM  = 2'd1,
    FWD_WB   = 2'd2
  } fwd_sel_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/byp_match.sv
module byp_match
  import byp_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic             mem_wen,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [IDX_W-1:0] wb_dst,
  output fwd_sel_e         sel
);
  logic hit_mem;
  logic hit_wb;

  // x0 is hard-wired zero, so a producer naming it is never a source
  assign hit_mem = mem_wen && (mem_dst != '0) && (mem_dst == src_idx);
  assign hit_wb  = wb_wen  && (wb_dst  != '0) && (wb_dst  == src_idx);

  always_comb begin
    if (hit_mem)     sel = FWD_MEM;   // newer value wins
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_NONE;
  end
endmodule

// File: rtl/byp_opmux.sv
module byp_opmux
  import byp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_sel_e        sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] mem_val,
  input  logic [XLEN-1:0] wb_val,
  output logic [XLEN-1:0] out_val
);
  always_comb begin
    case (sel)
      FWD_MEM: out_val = mem_val;
      FWD_WB:  out_val = wb_val;
      default: out_val = rf_val;   // unused code 3 falls back to the file
    endcase
  end
endmodule

// File: rtl/byp_stage_reg.sv
module byp_stage_reg #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/ex_bypass_unit.sv
module ex_bypass_unit
  import byp_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int XLEN  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ex_src1_idx,
  input  logic [IDX_W-1:0] ex_src2_idx,
  input  logic [XLEN-1:0]  rf_src1_data,
  input  logic [XLEN-1:0]  rf_src2_data,
  input  logic             mem_wen,
  input  logic [IDX_W-1:0] mem_dst_idx,
  input  logic [XLEN-1:0]  mem_result,
  input  logic             wb_wen,
  input  logic [IDX_W-1:0] wb_dst_idx,
  input  logic [XLEN-1:0]  wb_result,
  output logic [1:0]       sel1_q,
  output logic [1:0]       sel2_q,
  output logic [XLEN-1:0]  opnd1_q,
  output logic [XLEN-1:0]  opnd2_q
);
  localparam int NSRC  = 2;
  localparam int SLOTW = SEL_W + XLEN;

  logic [IDX_W-1:0] src_idx [NSRC];
  logic [XLEN-1:0]  rf_val  [NSRC];
  logic [SLOTW-1:0] slot_d  [NSRC];
  logic [SLOTW-1:0] slot_q  [NSRC];

  assign src_idx[0] = ex_src1_idx;
  assign src_idx[1] = ex_src2_idx;
  assign rf_val[0]  = rf_src1_data;
  assign rf_val[1]  = rf_src2_data;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fwd_sel_e        sel;
    logic [XLEN-1:0] val;

    byp_match #(.IDX_W(IDX_W)) u_match (
      .src_idx (src_idx[g]),
      .mem_wen (mem_wen),
      .mem_dst (mem_dst_idx),
      .wb_wen  (wb_wen),
      .wb_dst  (wb_dst_idx),
      .sel     (sel)
    );

    byp_opmux #(.XLEN(XLEN)) u_mux (
      .sel     (sel),
      .rf_val  (rf_val[g]),
      .mem_val (mem_result),
      .wb_val  (wb_result),
      .out_val (val)
    );

    assign slot_d[g] = {sel, val};

    byp_stage_reg #(.W(SLOTW)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (slot_d[g]),
      .q   (slot_q[g])
    );
  end

  assign {sel1_q, opnd1_q} = slot_q[0];
  assign {sel2_q, opnd2_q} = slot_q[1];
endmodule

// File: rtl/ex_bypass_unit_chk.sv
module ex_bypass_unit_chk #(
  parameter int IDX_W = 5,
  parameter int XLEN  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] ex_src1_idx,
  input logic [IDX_W-1:0] ex_src2_idx,
  input logic [XLEN-1:0]  rf_src1_data,
  input logic [XLEN-1:0]  rf_src2_data,
  input logic             mem_wen,
  input logic [IDX_W-1:0] mem_dst_idx,
  input logic [XLEN-1:0]  mem_result,
  input logic             wb_wen,
  input logic [IDX_W-1:0] wb_dst_idx,
  input logic [XLEN-1:0]  wb_result,
  input logic [1:0]       sel1_q,
  input logic [1:0]       sel2_q,
  input logic [XLEN-1:0]  opnd1_q,
  input logic [XLEN-1:0]  opnd2_q
);
  logic m1, m2, w1, w2;
  assign m1 = mem_wen && (mem_dst_idx != '0) && (mem_dst_idx == ex_src1_idx);
  assign m2 = mem_wen && (mem_dst_idx != '0) && (mem_dst_idx == ex_src2_idx);
  assign w1 = wb_wen  && (wb_dst_idx  != '0) && (wb_dst_idx  == ex_src1_idx);
  assign w2 = wb_wen  && (wb_dst_idx  != '0) && (wb_dst_idx  == ex_src2_idx);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sel1_q == 2'd0 && sel2_q == 2'd0 && opnd1_q == '0 && opnd2_q == '0));

  a_r3_mem_src1: assert property (@(posedge clk) disable iff (rst)
    m1 |=> (sel1_q == 2'd1 && opnd1_q == $past(mem_result)));

  a_r8_mem_src2: assert property (@(posedge clk) disable iff (rst)
    m2 |=> (sel2_q == 2'd1 && opnd2_q == $past(mem_result)));

  a_r4_wb_src1: assert property (@(posedge clk) disable iff (rst)
    (!m1 && w1) |=> (sel1_q == 2'd2 && opnd1_q == $past(wb_result)));

  a_r4_wb_src2: assert property (@(posedge clk) disable iff (rst)
    (!m2 && w2) |=> (sel2_q == 2'd2 && opnd2_q == $past(wb_result)));

  a_r6_zero_src1: assert property (@(posedge clk) disable iff (rst)
    (ex_src1_idx == '0) |=> (sel1_q == 2'd0 && opnd1_q == $past(rf_src1_data)));

  a_r7_nomatch_src2: assert property (@(posedge clk) disable iff (rst)
    (!m2 && !w2) |=> (sel2_q == 2'd0 && opnd2_q == $past(rf_src2_data)));

  a_r9_no_code3: assert property (@(posedge clk) disable iff (rst)
    (sel1_q != 2'd3 && sel2_q != 2'd3));
endmodule

bind ex_bypass_unit ex_bypass_unit_chk #(.IDX_W(IDX_W), .XLEN(XLEN)) u_chk (.*);

// File: tb/ex_bypass_unit_test.sv
`timescale 1ns/1ps
module ex_bypass_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ex_src1_idx = '0, ex_src2_idx = '0;
  logic [31:0] rf_src1_data = '0, rf_src2_data = '0;
  logic        mem_wen = 1'b0, wb_wen = 1'b0;
  logic [4:0]  mem_dst_idx = '0, wb_dst_idx = '0;
  logic [31:0] mem_result = '0, wb_result = '0;
  logic [1:0]  sel1_q, sel2_q;
  logic [31:0] opnd1_q, opnd2_q;

  always #10 clk = ~clk;  // 50 MHz

  ex_bypass_unit uut (.*);

  typedef struct {
    logic [1:0]  s1, s2;
    logic [31:0] d1, d2;
    string       t1, t2;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   cycles  = 0;
  bit   done    = 0;

  // Reference models: committed register file and architectural newest values
  logic [31:0] rf_model [32];
  logic [31:0] arch     [32];
  logic        p_mem_w = 0, p_wb_w = 0;
  logic [4:0]  p_mem_d = 0, p_wb_d = 0;
  logic [31:0] p_mem_v = 0, p_wb_v = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic [4:0] s);
    if (p_mem_w && p_mem_d != 0 && p_mem_d == s) return 2'd1;
    if (p_wb_w && p_wb_d != 0 && p_wb_d == s)   return 2'd2;
    return 2'd0;
  endfunction

  function automatic string tag_of(logic [4:0] s, logic [1:0] sel);
    if (s == 0)    return "R6";
    if (sel == 2'd1) return (p_wb_w && p_wb_d == s) ? "R5" : "R3";
    if (sel == 2'd2) return "R4";
    return "R7";
  endfunction

  // Driver: advances the modelled pipeline one step and queues the expectation
  task automatic step(input bit pw, input logic [4:0] pd, input logic [31:0] pv,
                      input logic [4:0] s1, input logic [4:0] s2, input string note);
    exp_t e;
    @(negedge clk);
    if (p_wb_w && p_wb_d != 0) rf_model[p_wb_d] = p_wb_v;
    p_wb_w = p_mem_w; p_wb_d = p_mem_d; p_wb_v = p_mem_v;
    p_mem_w = pw;     p_mem_d = pd;     p_mem_v = pv;
    if (pw && pd != 0) arch[pd] = pv;
    mem_wen = p_mem_w; mem_dst_idx = p_mem_d; mem_result = p_mem_v;
    wb_wen  = p_wb_w;  wb_dst_idx  = p_wb_d;  wb_result  = p_wb_v;
    ex_src1_idx = s1; ex_src2_idx = s2;
    rf_src1_data = rf_model[s1]; rf_src2_data = rf_model[s2];
    e.s1 = exp_sel(s1); e.s2 = exp_sel(s2);
    e.d1 = arch[s1];    e.d2 = arch[s2];
    e.t1 = {note, tag_of(s1, e.s1), " src1"};
    e.t2 = {note, tag_of(s2, e.s2), " src2"};
    exp_q.push_back(e);
  endtask

  // Monitor: R2 - the item driven before an edge is checked just after it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.t1, " sel"},  {30'd0, sel1_q}, {30'd0, e.s1});  // R9: code 3 never expected
      chk({e.t2, " sel"},  {30'd0, sel2_q}, {30'd0, e.s2});
      chk({e.t1, " data"}, opnd1_q, e.d1);
      chk({e.t2, " data"}, opnd2_q, e.d2);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin rf_model[i] = '0; arch[i] = '0; end
    // R1: busy inputs during reset must not reach the outputs
    mem_wen = 1; mem_dst_idx = 5'd3; mem_result = 32'hDEAD_BEEF;
    ex_src1_idx = 5'd3; ex_src2_idx = 5'd3; rf_src1_data = 32'h1111; rf_src2_data = 32'h2222;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sel1", {30'd0, sel1_q}, 32'd0);
    chk("R1 sel2", {30'd0, sel2_q}, 32'd0);
    chk("R1 opnd1", opnd1_q, 32'd0);
    chk("R1 opnd2", opnd2_q, 32'd0);
    rst = 0;
    mem_wen = 0;

    // Directed: same register written by both older producers (R5)
    step(1, 5'd5, 32'hA000_0005, 5'd0, 5'd0, "");
    step(1, 5'd5, 32'hB000_0005, 5'd5, 5'd5, "R5dir ");
    // MEM producer disabled, WB still writes x5 (R7 on MEM, R4 via WB); src2 x0
    step(0, 5'd5, 32'hC000_0005, 5'd5, 5'd0, "R7dir ");
    // Producers target x0 with write-enable high (R6)
    step(1, 5'd0, 32'hEEEE_0000, 5'd0, 5'd0, "R6dir ");
    step(1, 5'd0, 32'hFFFF_0000, 5'd0, 5'd7, "R6dir ");
    // R8: operand 1 from MEM, operand 2 from WB in the same cycle
    step(1, 5'd9, 32'h0000_0909, 5'd0, 5'd0, "");
    step(1, 5'd10, 32'h0000_0A0A, 5'd10, 5'd9, "R8dir ");
    // R3: plain MEM hit on operand 2 only
    step(1, 5'd12, 32'h0000_0C0C, 5'd1, 5'd12, "R3dir ");

    // Random pipeline stream with a small index range for frequent collisions
    for (int k = 0; k < 600; k++) begin
      step(($urandom_range(0, 9) < 8), 5'($urandom_range(0, 3)), $urandom,
           5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), "rand ");
    end

    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) chk("R2 drain", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule